// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave with Lower-Half Write Lock

This block is a slave on a two-wire serial bus (I2C-compatible). It fronts a 256-entry, 8-bit memory kept in registers. A system clock oversamples SCL and SDA, and the block finds START and STOP conditions and the bit edges from those samples. It drives SDA only toward low, through an output enable, so that the line behaves like an open-drain wire.

A bus master addresses the block with a select byte. The upper nibble of that byte picks between two paths. The memory path handles byte and burst writes, current-address reads and random or sequential reads, all through one auto-incrementing word pointer. The protection path writes lock or unlock commands. While a lock is in force, writes to the lower half of the memory are thrown away. A reversible lock can be lifted. A permanent lock can never be lifted, and it also survives power-on reset. The power-good input holds the block silent and in reset while it is low; the memory contents are not cleared.

Top module: `i2c_eeprom_wp`

## Requirements
- R1: The select byte is {type[3:0], sel[2:0], rw} and is sent MSB first. The block acknowledges a memory select, where type is 4'b1010 and sel equals strap[2:0], with SDA low on the 9th clock. Any other type or a sel mismatch leaves SDA released.
- R2: A memory write sends a select with rw=0, then one word-address byte, then data bytes. The block acknowledges every one of these bytes and stores each data byte at the word pointer.
- R3: Reads return mem[pointer] MSB first. A select with rw=1 reads from the current pointer. A master ACK (SDA low) asks for the next byte. A master NoACK ends the burst, and the block then leaves SDA released.
- R4: The word pointer increments after every data byte, whether written or read, and wraps from FFh to 00h. A read that follows a write burst starts at the byte after the last one written.
- R5: A protection select (type 4'b0110, sel equal to strap, rw=0) is acknowledged only while hv_detect is high. It is followed by one command byte: 01h sets the reversible lock, 02h sets the permanent lock, 03h clears the reversible lock. Any other code is not acknowledged.
- R6: While either lock is set, data bytes aimed at 00h–7Fh are still acknowledged but are not stored. Addresses 80h–FFh can be written as usual.
- R7: Command 03h clears the reversible lock, and lower-half writes then take effect again.
- R8: Once the permanent lock is set, command 03h is not acknowledged. The lock stays set through later commands and through por_n pulses.
- R9: While por_n is low, the block never pulls SDA low. A por_n pulse clears the word pointer and the reversible lock and leaves the memory contents unchanged.
- R10: The block starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| por_n | input | 1 | Power-good; low holds the block in reset |
| scl | input | 1 | Serial clock from the master |
| sda_in | input | 1 | Level of the shared data line |
| sda_oe | output | 1 | High pulls the data line low |
| strap | input | 3 | Address straps matched against the select bits |
| hv_detect | input | 1 | High-voltage detect that enables protection commands |

## Verification
The bench first fills the whole memory and then runs seeded random write bursts and sequential reads against a model. Its directed cases cover a burst that crosses FFh. A design that fails to wrap the pointer, or that keeps one pointer for reads and another for writes, returns the wrong bytes there. Lock tests write to 7Fh and to 80h on each side of the boundary. A design that decodes the boundary wrongly either loses upper-half data or lets lower-half bytes through. The bench also sends a clear command under the permanent lock, sends commands with hv_detect low, and pulses por_n. A design that gets these wrong acknowledges the clear, acknowledges the commands, or loses memory contents or the permanent lock across the reset.

// File: rtl/i2c_eeprom_wp.sv
module i2c_eeprom_wp #(
  parameter logic [3:0] MEM_TYPE = 4'b1010,
  parameter logic [3:0] CTL_TYPE = 4'b0110,
  parameter int AW = 8,
  parameter int LOCK_TOP = 128
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       scl,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [2:0] strap,
  input  logic       hv_detect
);
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] CMD_REV = 8'h01, CMD_PERM = 8'h02, CMD_CLR = 8'h03;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WDATA, S_CMD, S_ACK, S_RDATA, S_RACK} st_t;
  st_t state, nxt;

  logic [2:0]    scl_q, sda_q;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] addr;
  logic          rev_lock, mack;
  logic          perm_lock = 1'b0;

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_c   = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  wire stop_c    = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
  wire byte_done = scl_fall && bitcnt == 4'd8;
  wire sel_match = shreg[3:1] == strap;
  wire mem_sel   = shreg[7:4] == MEM_TYPE && sel_match;
  wire ctl_sel   = shreg[7:4] == CTL_TYPE && sel_match && !shreg[0] && hv_detect;
  wire low_hit   = int'(addr) < LOCK_TOP;
  wire cmd_ok    = shreg == CMD_REV || shreg == CMD_PERM || (shreg == CMD_CLR && !perm_lock);
  wire [7:0] rd_byte = mem[addr];

  always_ff @(posedge clk)
    if (por_n && state == S_WDATA && byte_done && !((rev_lock | perm_lock) && low_hit))
      mem[addr] <= shreg;

  always_ff @(posedge clk)
    if (por_n && state == S_CMD && byte_done && shreg == CMD_PERM)
      perm_lock <= 1'b1;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      scl_q    <= 3'b111;
      sda_q    <= 3'b111;
      state    <= S_IDLE;
      nxt      <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      addr     <= '0;
      rev_lock <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      scl_q <= {scl_q[1:0], scl};
      sda_q <= {sda_q[1:0], sda_in};
      if (start_c) begin
        state  <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_DEV, S_ADDR, S_WDATA, S_CMD:
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_q[1]};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= '0;
              state  <= S_ACK;
              sda_oe <= 1'b1;
              nxt    <= S_WDATA;
              case (state)
                S_DEV:
                  if (mem_sel) nxt <= shreg[0] ? S_RDATA : S_ADDR;
                  else if (ctl_sel) nxt <= S_CMD;
                  else begin
                    state  <= S_IDLE;
                    sda_oe <= 1'b0;
                  end
                S_ADDR:  addr <= shreg[AW-1:0];
                S_WDATA: addr <= addr + 1'b1;
                S_CMD:
                  if (!cmd_ok) begin
                    state  <= S_IDLE;
                    sda_oe <= 1'b0;
                  end else begin
                    nxt <= S_IDLE;
                    if (shreg == CMD_REV) rev_lock <= 1'b1;
                    if (shreg == CMD_CLR) rev_lock <= 1'b0;
                  end
                default: ;
              endcase
            end
          S_ACK:
            if (scl_fall) begin
              bitcnt <= '0;
              state  <= nxt;
              sda_oe <= 1'b0;
              if (nxt == S_RDATA) begin
                shreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
                addr   <= addr + 1'b1;
              end
            end
          S_RDATA:
            if (scl_rise) begin
              shreg  <= {shreg[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= S_RACK;
              end else sda_oe <= ~shreg[7];
            end
          S_RACK:
            if (scl_rise) mack <= ~sda_q[1];
            else if (scl_fall) begin
              if (mack) begin
                state  <= S_RDATA;
                bitcnt <= '0;
                shreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
                addr   <= addr + 1'b1;
              end else state <= S_IDLE;
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_wp_checks.sv
module i2c_eeprom_wp_checks (
  input logic clk,
  input logic por_n,
  input logic scl,
  input logic sda_oe,
  input logic perm_lock,
  input logic rev_lock
);
  assert_oe_rises_scl_low_R10: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sda_oe) |-> !scl);
  assert_silent_in_reset_R9: assert property (@(posedge clk)
    !por_n |=> !sda_oe);
  assert_rev_cleared_R9: assert property (@(posedge clk)
    !por_n |=> !rev_lock);
  assert_perm_sticky_R8: assert property (@(posedge clk)
    perm_lock |=> perm_lock);
endmodule

bind i2c_eeprom_wp i2c_eeprom_wp_checks u_checks (.*);

// File: tb/i2c_eeprom_wp_bench.sv
module i2c_eeprom_wp_bench;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [3:0] MT = 4'b1010, CT = 4'b0110;

  logic clk = 0, por_n = 0, scl = 1, sda_m = 1, hv = 0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  i2c_eeprom_wp u_i2c_eeprom_wp (.clk(clk), .por_n(por_n), .scl(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .strap(STRAP), .hv_detect(hv));

  int total = 0, passed = 0;
  logic [7:0] m_mem [256];
  logic [7:0] m_addr = 0;
  bit m_rev = 0, m_perm = 0;

  function automatic logic [7:0] dsel(logic [3:0] t, logic [2:0] s, logic rw);
    return {t, s, rw};
  endfunction
  function automatic bit locked_at(logic [7:0] a);
    return (m_rev || m_perm) && a < 8'h80;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic tick(); repeat (5) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; tick(); scl = 1; tick(); sda_m = 0; tick(); scl = 0; tick(); endtask
  task automatic bstop(); sda_m = 0; tick(); scl = 1; tick(); sda_m = 1; tick(); endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(); scl = 1; tick(); scl = 0; tick();
    end
    sda_m = 1; tick(); scl = 1; tick(); ack = !sda_line; scl = 0; tick();
  endtask

  task automatic recv(input bit mack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(); scl = 1; tick(); d[i] = sda_line; scl = 0;
    end
    tick(); sda_m = !mack; tick(); scl = 1; tick(); scl = 0; tick(); sda_m = 1;
  endtask

  task automatic wr(input logic [7:0] a, input int n, input bit rnd, input logic [7:0] v);
    bit ack;
    logic [7:0] d;
    bstart();
    send(dsel(MT, STRAP, 0), ack); check("R1 write select ack", ack, 1);
    send(a, ack); check("R2 address ack", ack, 1);
    m_addr = a;
    for (int i = 0; i < n; i++) begin
      d = rnd ? 8'($urandom) : v + 8'(i);
      send(d, ack); check("R2 data ack (R6 acks locked too)", ack, 1);
      if (!locked_at(m_addr)) m_mem[m_addr] = d;
      m_addr++;
    end
    bstop();
  endtask

  task automatic rd_burst(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, d);
      check(tag, d, m_mem[m_addr]);
      m_addr++;
    end
    tick();
    check("R3 released after NoACK", sda_oe, 0);
    bstop();
  endtask

  task automatic rd(input logic [7:0] a, input int n, input string tag);
    bit ack;
    bstart();
    send(dsel(MT, STRAP, 0), ack);
    send(a, ack); m_addr = a;
    bstart();
    send(dsel(MT, STRAP, 1), ack); check("R1 read select ack", ack, 1);
    rd_burst(n, tag);
  endtask

  task automatic cur_rd(input int n, input string tag);
    bit ack;
    bstart();
    send(dsel(MT, STRAP, 1), ack); check("R3 current read select ack", ack, 1);
    rd_burst(n, tag);
  endtask

  task automatic cmd(input logic [7:0] code, input bit exp_sel, input bit exp_cmd, input string tag);
    bit ack;
    bstart();
    send(dsel(CT, STRAP, 0), ack); check({tag, " select"}, ack, exp_sel);
    if (ack) begin
      send(code, ack); check({tag, " code"}, ack, exp_cmd);
      if (ack && code == 8'h01) m_rev = 1;
      if (ack && code == 8'h02) m_perm = 1;
      if (ack && code == 8'h03) m_rev = 0;
    end
    bstop();
  endtask

  task automatic por_pulse();
    por_n = 0; repeat (10) @(negedge clk); por_n = 1; repeat (5) @(negedge clk);
    m_addr = 0; m_rev = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    check("R9 quiet in reset", sda_oe, 0);
    por_n = 1; repeat (5) @(negedge clk);

    for (int b = 0; b < 8; b++) wr(8'(b * 32), 32, 1, 0);
    rd(8'h00, 6, "R3 sequential read after fill");

    for (int t = 0; t < 12; t++) begin
      wr(8'($urandom), 1 + int'($urandom % 5), 1, 0);
      rd(8'($urandom), 1 + int'($urandom % 4), "R2 random readback");
    end

    wr(8'hFE, 4, 0, 8'h40);
    rd(8'hFE, 4, "R4 wrap FF->00 readback");
    wr(8'h20, 2, 0, 8'h77);
    cur_rd(2, "R4 pointer shared write->read");

    bstart(); send(dsel(MT, STRAP ^ 3'b001, 0), ack); bstop();
    check("R1 strap mismatch nack", ack, 0);
    bstart(); send(dsel(4'b1011, STRAP, 0), ack); bstop();
    check("R1 wrong type nack", ack, 0);

    hv = 0; cmd(8'h01, 0, 0, "R5 no hv");
    wr(8'h10, 1, 0, 8'h11);
    rd(8'h10, 1, "R5 no lock without hv");
    hv = 1; cmd(8'h55, 1, 0, "R5 bad code");
    cmd(8'h01, 1, 1, "R5 set reversible");
    wr(8'h7F, 2, 0, 8'hC3);
    rd(8'h7F, 2, "R6 7F locked, 80 open");
    wr(8'h10, 1, 0, 8'h99);
    rd(8'h10, 1, "R6 low write ignored");

    cmd(8'h03, 1, 1, "R7 clear");
    wr(8'h10, 1, 0, 8'h5A);
    rd(8'h10, 1, "R7 low write after clear");

    cmd(8'h01, 1, 1, "R9 relock");
    por_pulse();
    cur_rd(1, "R9 pointer zero, memory kept");
    wr(8'h05, 1, 0, 8'h3C);
    rd(8'h05, 1, "R9 reversible lock cleared");

    por_n = 0;
    bstart(); send(dsel(MT, STRAP, 0), ack); bstop();
    check("R9 no ack in reset", ack, 0);
    por_n = 1; repeat (5) @(negedge clk);
    m_addr = 0;

    cmd(8'h02, 1, 1, "R8 set permanent");
    cmd(8'h03, 1, 0, "R8 clear refused");
    wr(8'h40, 1, 0, 8'hEE);
    rd(8'h40, 1, "R8 low write ignored");
    por_pulse();
    wr(8'h41, 1, 0, 8'hDD);
    rd(8'h41, 1, "R8 lock survives reset");
    wr(8'hC0, 1, 0, 8'hA1);
    rd(8'hC0, 1, "R6 upper half writable");
    hv = 0;

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule